// File: doc/BRIEF.md
# SPI Slave with Low-Power Completion Deferral

This block is a byte-wide SPI slave. It fixes clock mode 0: the master samples and the slave samples on the rising SCK edge, and the slave changes MISO on the falling edge. Frames are 8 bits, sent MSB first. A frame begins when the active-low select line is asserted. SCK, MOSI and the select line are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than SCK. The CPU side has three strobes: one that loads a transmit byte, a status read, and a data read. It also sees a received-data bus, a completion flag and an interrupt line.

The module can be asked to enter a low-power state through either of two request inputs, wait or stop, which are treated alike. While the module is in that state, the shifter keeps running on the master's clock and stays bit-aligned. What changes is the CPU-visible side. A byte that completes while the module is in low power does not update the received-data bus or the flag at that moment. It is held back and handed over in the cycle after the module leaves low power. This happens only if the module entered low power with a frame under way, meaning the select line was asserted. A low-power period that both starts and ends with the select line released drops any byte that completed inside it.

Top module: `spi_lp_slave`

## Requirements
- R1: With the select line low, after the 8th rising SCK edge the byte sampled from MOSI (first bit = bit 7) appears on `rx_data_o` and `done_o` goes high, provided no low-power request is active.
- R2: A byte loaded by `tx_wr_i` before a frame is driven on MISO, bit 7 first. The first bit is valid before the first rising SCK edge, and each later bit changes after a falling edge.
- R3: If no byte has been loaded since the previous frame, the slave transmits the byte it received in that previous frame.
- R4: `done_o` clears only when a data read (`data_rd_i`) follows a status read (`stat_rd_i`) made while the flag was set. A data read without that earlier status read leaves the flag set.
- R5: `irq_o` is high exactly when `done_o` is high and `enable_i` is high. It never asserts while `enable_i` is low.
- R6: The low-power state is active while `wait_req_i` or `stop_req_i` is high. Shifting continues in that state, and `rx_data_o` does not change while it lasts.
- R7: If low power is entered while the select line is asserted, and the frame then completes inside low power, `done_o` and `rx_data_o` stay unchanged until the request drops. The byte and the flag appear in the following cycle.
- R8: If low power is entered and left with the select line released, a frame completed inside it sets no flag and does not change `rx_data_o`.
- R9: If low power is entered while idle and left during a frame, that frame completes normally as in R1.
- R10: After reset `rx_data_o` is 0, `done_o` is 0 and `irq_o` is 0.
- R11: Releasing the select line before 8 bits discards the partial frame, and the next frame is received aligned from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| enable_i | input | 1 | Module enable, gates the interrupt |
| wait_req_i | input | 1 | Wait low-power request |
| stop_req_i | input | 1 | Stop low-power request |
| tx_wr_i | input | 1 | Strobe that loads `tx_data_i` |
| tx_data_i | input | FRAME_W | Byte to transmit in the next frame |
| stat_rd_i | input | 1 | Status read strobe |
| data_rd_i | input | 1 | Data read strobe |
| rx_data_o | output | FRAME_W | Last delivered received byte |
| done_o | output | 1 | Transfer-complete flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the three low-power cases.

- **Entry mid-frame.** A design that did not defer would raise the flag inside the low-power window. A design that dropped the held byte would never deliver it.
- **Idle-to-idle window.** A careless design would deliver a stale or fresh byte here even though the frame lay entirely inside the window.
- **Exit mid-frame.** A design that latched the entry state too eagerly would lose this frame.

The bench also covers the remaining corner cases. It checks the echo of the last received byte when no new transmit byte was loaded. It checks the two-step flag clear, where a lone data read must leave the flag set. It checks interrupt gating by the enable. It checks a frame cut short by select release, which would leave a miscounting shifter misaligned on the next byte.

// File: rtl/spi_lp_pkg.sv
package spi_lp_pkg;

    typedef enum logic [1:0] {
        LP_NONE  = 2'd0,
        LP_ENTER = 2'd1,
        LP_EXIT  = 2'd2,
        LP_HOLD  = 2'd3
    } lp_evt_t;

    function automatic lp_evt_t lp_classify(input logic now, input logic prev);
        lp_evt_t e;
        case ({prev, now})
            2'b01:   e = LP_ENTER;
            2'b10:   e = LP_EXIT;
            2'b11:   e = LP_HOLD;
            default: e = LP_NONE;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/spi_lp_sync.sv
module spi_lp_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign stg_d[g] = async_i;
            end else begin : g_next
                assign stg_d[g] = stg_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_lp_shifter.sv
module spi_lp_shifter #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          ssn_s,
    input  logic [FW-1:0] tx_data_i,
    input  logic          tx_valid_i,
    output logic          miso_o,
    output logic          start_o,
    output logic          done_o,
    output logic [FW-1:0] byte_o,
    output logic          busy_o
);

    localparam int              CW   = (FW > 1) ? $clog2(FW) : 1;
    localparam logic [CW-1:0]   LAST = CW'(FW - 1);

    typedef struct packed {
        logic [FW-1:0] shreg;
        logic          smp;
        logic [CW-1:0] cnt;
        logic          sck_prev;
        logic          ssn_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      sck_rise, sck_fall;

    assign sck_rise = sck_s & ~st_q.sck_prev;
    assign sck_fall = ~sck_s & st_q.sck_prev;

    always_comb begin
        st_d          = st_q;
        start_o       = 1'b0;
        done_o        = 1'b0;
        byte_o        = {st_q.shreg[FW-2:0], mosi_s};
        st_d.sck_prev = sck_s;
        st_d.ssn_prev = ssn_s;
        if (ssn_s) begin
            st_d.cnt = '0;
        end else if (st_q.ssn_prev) begin
            start_o  = 1'b1;
            st_d.cnt = '0;
            if (tx_valid_i) st_d.shreg = tx_data_i;
        end else begin
            if (sck_rise) begin
                st_d.smp = mosi_s;
                if (st_q.cnt == LAST) begin
                    st_d.cnt = '0;
                    done_o   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (sck_fall) begin
                st_d.shreg = {st_q.shreg[FW-2:0], st_q.smp};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{shreg: '0, smp: 1'b0, cnt: '0, sck_prev: 1'b0, ssn_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = ~ssn_s;
    assign miso_o = ~ssn_s & st_q.shreg[FW-1];

endmodule

// File: rtl/spi_lp_ctrl.sv
module spi_lp_ctrl
    import spi_lp_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lp_i,
    input  logic          en_i,
    input  logic          busy_i,
    input  logic          start_i,
    input  logic          done_pulse_i,
    input  logic [FW-1:0] byte_i,
    input  logic          tx_wr_i,
    input  logic [FW-1:0] tx_data_i,
    input  logic          stat_rd_i,
    input  logic          data_rd_i,
    output logic [FW-1:0] rx_o,
    output logic          done_o,
    output logic          irq_o,
    output logic [FW-1:0] tx_data_o,
    output logic          tx_valid_o
);

    typedef struct packed {
        logic [FW-1:0] rx;
        logic [FW-1:0] hold;
        logic [FW-1:0] txbuf;
        logic          txval;
        logic          done;
        logic          armed;
        logic          pend;
        logic          entry_mid;
        logic          lp_prev;
    } ctrl_st_t;

    ctrl_st_t      st_d, st_q;
    lp_evt_t       evt;
    logic          set_flag;
    logic          mid_now;
    logic [FW-1:0] new_rx;

    always_comb begin
        st_d         = st_q;
        st_d.lp_prev = lp_i;
        evt          = lp_classify(lp_i, st_q.lp_prev);
        set_flag     = 1'b0;
        new_rx       = st_q.rx;
        mid_now      = st_q.entry_mid;

        case (evt)
            LP_ENTER: begin
                mid_now   = busy_i;
                st_d.pend = 1'b0;
            end
            LP_EXIT: begin
                if (st_q.pend) begin
                    set_flag  = 1'b1;
                    new_rx    = st_q.hold;
                    st_d.pend = 1'b0;
                end
            end
            default: ;
        endcase

        st_d.entry_mid = (evt == LP_ENTER || evt == LP_HOLD) ? mid_now : 1'b0;

        if (done_pulse_i) begin
            if (!lp_i) begin
                set_flag = 1'b1;
                new_rx   = byte_i;
            end else if (mid_now) begin
                st_d.hold      = byte_i;
                st_d.pend      = 1'b1;
                st_d.entry_mid = 1'b0;
            end
        end

        if (data_rd_i && st_q.armed) begin
            st_d.done  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (stat_rd_i && st_q.done) begin
            st_d.armed = 1'b1;
        end
        if (set_flag) begin
            st_d.done  = 1'b1;
            st_d.armed = 1'b0;
            st_d.rx    = new_rx;
        end

        if (tx_wr_i) begin
            st_d.txbuf = tx_data_i;
            st_d.txval = 1'b1;
        end else if (start_i) begin
            st_d.txval = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_o       = st_q.rx;
    assign done_o     = st_q.done;
    assign irq_o      = en_i & st_q.done;
    assign tx_data_o  = st_q.txbuf;
    assign tx_valid_o = st_q.txval;

endmodule

// File: rtl/spi_lp_slave.sv
module spi_lp_slave #(
    parameter int FRAME_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_i,
    input  logic               mosi_i,
    input  logic               ss_n_i,
    output logic               miso_o,
    input  logic               enable_i,
    input  logic               wait_req_i,
    input  logic               stop_req_i,
    input  logic               tx_wr_i,
    input  logic [FRAME_W-1:0] tx_data_i,
    input  logic               stat_rd_i,
    input  logic               data_rd_i,
    output logic [FRAME_W-1:0] rx_data_o,
    output logic               done_o,
    output logic               irq_o
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0]   pins_s;
    logic               frm_start, frm_done, frm_busy;
    logic [FRAME_W-1:0] frm_byte;
    logic [FRAME_W-1:0] txb_data;
    logic               txb_valid;
    logic               lp_req;

    assign lp_req = wait_req_i | stop_req_i;

    spi_lp_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sck_i, mosi_i, ss_n_i}),
        .sync_o  (pins_s)
    );

    spi_lp_shifter #(
        .FW (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (pins_s[2]),
        .mosi_s     (pins_s[1]),
        .ssn_s      (pins_s[0]),
        .tx_data_i  (txb_data),
        .tx_valid_i (txb_valid),
        .miso_o     (miso_o),
        .start_o    (frm_start),
        .done_o     (frm_done),
        .byte_o     (frm_byte),
        .busy_o     (frm_busy)
    );

    spi_lp_ctrl #(
        .FW (FRAME_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lp_i         (lp_req),
        .en_i         (enable_i),
        .busy_i       (frm_busy),
        .start_i      (frm_start),
        .done_pulse_i (frm_done),
        .byte_i       (frm_byte),
        .tx_wr_i      (tx_wr_i),
        .tx_data_i    (tx_data_i),
        .stat_rd_i    (stat_rd_i),
        .data_rd_i    (data_rd_i),
        .rx_o         (rx_data_o),
        .done_o       (done_o),
        .irq_o        (irq_o),
        .tx_data_o    (txb_data),
        .tx_valid_o   (txb_valid)
    );

endmodule

// File: rtl/spi_lp_slave_chk.sv
module spi_lp_slave_chk #(
    parameter int FW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable_i,
    input logic          wait_req_i,
    input logic          stop_req_i,
    input logic          data_rd_i,
    input logic [FW-1:0] rx_data_o,
    input logic          done_o,
    input logic          irq_o
);

    // R5: interrupt must stay low whenever the enable is low
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !irq_o);

    // R7: the flag may only rise from a decision taken outside low power
    p_no_flag_in_lp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !$past(wait_req_i | stop_req_i));

    // R6: received data stays frozen across low-power cycles
    p_rx_frozen_lp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wait_req_i | stop_req_i) |-> $stable(rx_data_o));

    // R1: a new received byte is always accompanied by the flag
    p_rx_with_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data_o) |-> done_o);

    // R4: the flag only falls as a result of a data read
    p_clear_by_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(data_rd_i));

endmodule

bind spi_lp_slave spi_lp_slave_chk #(.FW(FRAME_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .wait_req_i (wait_req_i),
    .stop_req_i (stop_req_i),
    .data_rd_i  (data_rd_i),
    .rx_data_o  (rx_data_o),
    .done_o     (done_o),
    .irq_o      (irq_o)
);

// File: tb/spi_lp_slave_tb_top.sv
module spi_lp_slave_tb_top;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic       miso;
    logic       en = 1'b1, wait_req = 1'b0, stop_req = 1'b0;
    logic       tx_wr = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       done, irq;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    spi_lp_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n),
        .miso_o(miso), .enable_i(en), .wait_req_i(wait_req), .stop_req_i(stop_req),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
        .rx_data_o(rx_data), .done_o(done), .irq_o(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic stat_read;
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic data_read;
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag;
        stat_read();
        data_read();
    endtask

    // lp_on/lp_off: bit index at which the low-power request changes, -1 for none
    task automatic spi_frame(input logic [7:0] tb, output logic [7:0] got,
                             input int lp_on, input int lp_off, input bit use_stop);
        @(negedge clk); ss_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < 8; i++) begin
            if (i == lp_on)  begin if (use_stop) stop_req = 1'b1; else wait_req = 1'b1; end
            if (i == lp_off) begin stop_req = 1'b0; wait_req = 1'b0; end
            mosi = tb[7-i];
            idle(HALF);
            got[7-i] = miso;
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
        idle(HALF);
        ss_n = 1'b1;
        idle(HALF);
    endtask

    task automatic t_reset;
        chk("R10", "rx after reset", rx_data, 8'h00);
        chk("R10", "flag after reset", {7'd0, done}, 8'h00);
        chk("R10", "irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_basic;
        logic [7:0] g;
        cpu_write(8'hA5);
        spi_frame(8'h3C, g, -1, -1, 1'b0);
        chk("R2", "miso byte", g, 8'hA5);
        chk("R1", "rx byte", rx_data, 8'h3C);
        chk("R1", "flag set", {7'd0, done}, 8'h01);
        chk("R5", "irq with enable", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_clear;
        data_read();
        chk("R4", "lone data read keeps flag", {7'd0, done}, 8'h01);
        clear_flag();
        chk("R4", "flag cleared by sequence", {7'd0, done}, 8'h00);
        chk("R5", "irq follows flag", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_echo;
        logic [7:0] g;
        spi_frame(8'h81, g, -1, -1, 1'b0);
        chk("R3", "echo of last received", g, 8'h3C);
        chk("R1", "rx second frame", rx_data, 8'h81);
        clear_flag();
    endtask

    task automatic t_enable;
        logic [7:0] g;
        en = 1'b0;
        cpu_write(8'h11);
        spi_frame(8'h42, g, -1, -1, 1'b0);
        chk("R5", "irq masked", {7'd0, irq}, 8'h00);
        chk("R1", "flag set while disabled", {7'd0, done}, 8'h01);
        @(negedge clk); en = 1'b1;
        @(negedge clk);
        chk("R5", "irq after enable", {7'd0, irq}, 8'h01);
        clear_flag();
    endtask

    task automatic t_defer;
        logic [7:0] g;
        cpu_write(8'h96);
        spi_frame(8'hC3, g, 3, -1, 1'b0);
        chk("R6", "miso during wait", g, 8'h96);
        chk("R7", "flag held in wait", {7'd0, done}, 8'h00);
        chk("R7", "rx held in wait", rx_data, 8'h42);
        @(negedge clk); wait_req = 1'b0;
        idle(2);
        chk("R7", "flag after exit", {7'd0, done}, 8'h01);
        chk("R7", "rx after exit", rx_data, 8'hC3);
        clear_flag();
    endtask

    task automatic t_idle_lp;
        logic [7:0] g;
        @(negedge clk); stop_req = 1'b1;
        idle(4);
        spi_frame(8'h5A, g, -1, -1, 1'b1);
        @(negedge clk); stop_req = 1'b0;
        idle(4);
        chk("R8", "no flag for idle window", {7'd0, done}, 8'h00);
        chk("R8", "rx untouched", rx_data, 8'hC3);
    endtask

    task automatic t_exit_mid;
        logic [7:0] g;
        @(negedge clk); stop_req = 1'b1;
        idle(4);
        spi_frame(8'h6E, g, -1, 4, 1'b1);
        chk("R9", "rx for exit mid-frame", rx_data, 8'h6E);
        chk("R9", "flag for exit mid-frame", {7'd0, done}, 8'h01);
        clear_flag();
    endtask

    task automatic t_abort;
        logic [7:0] g;
        @(negedge clk); ss_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            idle(HALF); sck = 1'b1;
            idle(HALF); sck = 1'b0;
        end
        idle(HALF); ss_n = 1'b1;
        idle(HALF);
        chk("R11", "no flag for partial", {7'd0, done}, 8'h00);
        spi_frame(8'h24, g, -1, -1, 1'b0);
        chk("R11", "aligned after abort", rx_data, 8'h24);
        clear_flag();
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_basic();
        t_clear();
        t_echo();
        t_enable();
        t_defer();
        t_idle_lp();
        t_exit_mid();
        t_abort();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule